// File: doc/BRIEF.md
# Indirect configuration access port

This block is a register slave on a host bus. It lets software reach downstream configuration registers and I/O ports through a few fixed registers. Software first writes a target token into the address register. A later access to one of two data windows then starts exactly one downstream cycle. The configuration window produces a configuration cycle and the I/O window produces an I/O-port cycle. A host read produces a downstream read, and a host write produces a downstream write.

The address is latched once and reused by every following window access. The width and lane of each transfer come from the host access size and from the low bits of the window offset that was touched. They do not come from the token.

The host bus is held (ready low) until the downstream side answers. Read data comes back only on the lanes that were enabled.

Top module: `cfgp_port`

## Requirements
- R1: After reset the address register reads as zero, and both `h_ready` and `dn_req` are low.
- R2: A write to offset 0x064 stores `h_wdata` in the address register. A read of 0x064 returns the last value written.
- R3: An access to offset 0x068 to 0x06B launches a configuration cycle (`dn_io` = 0). An access to 0x06C to 0x06F launches an I/O-port cycle (`dn_io` = 1). In both cases `dn_we` equals `h_we`.
- R4: A configuration cycle drives `dn_addr` as the address register with bits 1:0 forced to zero. An I/O-port cycle drives the address register unmodified.
- R5: Access size is encoded in `h_size` as 0 = byte, 1 = halfword, 2 or 3 = word. `dn_be` is set as follows:
  - a byte sets bit `h_addr[1:0]`;
  - a halfword sets 4'b0011 when `h_addr[1]` is 0 and 4'b1100 when it is 1, so offsets 1 and 3 act as 0 and 2;
  - a word sets 4'b1111.
- R6: `dn_req` rises one cycle after a window access is accepted. While `dn_ack` is low it stays high with every downstream field stable, and `h_ready` stays low. In the cycle after the one with `dn_req` and `dn_ack` both high, `h_ready` is high for exactly one cycle and `dn_req` is low.
- R7: For a window read, `h_rdata` carries `dn_rdata` on the enabled byte lanes and zero on the other lanes.
- R8: For a window write, `dn_wdata` equals `h_wdata` unchanged.
- R9: The address register is reused, unchanged, by any number of window accesses until software writes it again.
- R10: An access to any other offset completes with `h_ready` one cycle later and launches no downstream cycle. A read of such an offset returns zero, and a write has no effect on the address register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, held until h_ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 12 | Host byte offset in the register space |
| h_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| h_wdata | input | 32 | Host write data, lane aligned |
| h_rdata | output | 32 | Host read data |
| h_ready | output | 1 | One-cycle completion pulse |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_io | output | 1 | 0 configuration cycle, 1 I/O-port cycle |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_addr | output | 32 | Downstream target address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream response strobe |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The hardest case to reach is a long downstream stall with a misaligned halfword. During that stall every downstream field must stay frozen and the host must see no completion. The stimulus holds `dn_ack` low for several cycles on accesses at window offsets 1 and 3, and also on accesses with no stall at all. A per-clock model checks `dn_req` and `dn_addr` against the expected pending state throughout. An unmapped write is followed by a read-back of the address register, which shows through the normal interface that the write had no effect.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_ADDR = 2'd1,
      HIT_CFG  = 2'd2,
      HIT_IO   = 2'd3
   } hit_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cfgp_lane_dec.sv
module cfgp_lane_dec
   import cfgp_pkg::*;
#(
   parameter int unsigned LANES = 4,
   localparam int unsigned OFS_W = $clog2(LANES)
) (
   input  xfer_size_e       size,
   input  logic [OFS_W-1:0] ofs,
   output logic [LANES-1:0] be
);
   logic [OFS_W-1:0] half_base;
   logic [OFS_W-1:0] word_base;

   always_comb begin
      half_base = ofs & ~OFS_W'(1);
      word_base = ofs & ~OFS_W'(3);
      case (size)
         SZ_BYTE: be = LANES'(1) << ofs;
         SZ_HALF: be = LANES'(3) << half_base;
         default: be = LANES'(15) << word_base;
      endcase
   end
endmodule

// File: rtl/cfgp_win_dec.sv
module cfgp_win_dec
   import cfgp_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OFS_W    = 2,
   parameter int unsigned ADDR_OFS = 'h064,
   parameter int unsigned CFG_OFS  = 'h068,
   parameter int unsigned IO_OFS   = 'h06C
) (
   input  logic [ADDR_W-1:0] addr,
   output hit_e              hit
);
   localparam int unsigned TAG_W = ADDR_W - OFS_W;
   localparam logic [TAG_W-1:0] ADDR_TAG = TAG_W'(ADDR_OFS >> OFS_W);
   localparam logic [TAG_W-1:0] CFG_TAG  = TAG_W'(CFG_OFS >> OFS_W);
   localparam logic [TAG_W-1:0] IO_TAG   = TAG_W'(IO_OFS >> OFS_W);

   logic [TAG_W-1:0] tag;

   always_comb begin
      tag = addr[ADDR_W-1:OFS_W];
      if (tag == ADDR_TAG)      hit = HIT_ADDR;
      else if (tag == CFG_TAG)  hit = HIT_CFG;
      else if (tag == IO_TAG)   hit = HIT_IO;
      else                      hit = HIT_NONE;
   end
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
   import cfgp_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_OFS = 'h064,
   parameter int unsigned CFG_OFS  = 'h068,
   parameter int unsigned IO_OFS   = 'h06C,
   localparam int unsigned LANES   = DATA_W / 8,
   localparam int unsigned OFS_W   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [1:0]        h_size,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   output logic              h_ready,
   output logic              dn_req,
   output logic              dn_io,
   output logic              dn_we,
   output logic [DATA_W-1:0] dn_addr,
   output logic [LANES-1:0]  dn_be,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_ack,
   input  logic [DATA_W-1:0] dn_rdata
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cfgp_port: windows are word spaced, DATA_W must be 32");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("cfgp_port: ADDR_W too small for the window offsets");
      end
   endgenerate

   hit_e             hit;
   logic [LANES-1:0] be_now;
   logic [DATA_W-1:0] rd_lanes;

   seq_state_e        state_q;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] rdata_q;
   logic              ready_q;
   logic              req_q;
   logic              io_q;
   logic              we_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;

   cfgp_win_dec #(
      .ADDR_W  (ADDR_W),
      .OFS_W   (OFS_W),
      .ADDR_OFS(ADDR_OFS),
      .CFG_OFS (CFG_OFS),
      .IO_OFS  (IO_OFS)
   ) i_dec (
      .addr(h_addr),
      .hit (hit)
   );

   cfgp_lane_dec #(
      .LANES(LANES)
   ) i_lane (
      .size(xfer_size_e'(h_size)),
      .ofs (h_addr[OFS_W-1:0]),
      .be  (be_now)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_rd_lane
         assign rd_lanes[l*8 +: 8] = be_q[l] ? dn_rdata[l*8 +: 8] : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         rdata_q <= '0;
         ready_q <= 1'b0;
         req_q   <= 1'b0;
         io_q    <= 1'b0;
         we_q    <= 1'b0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (h_req) begin
                  case (hit)
                     HIT_ADDR: begin
                        if (h_we) addr_q  <= h_wdata;
                        else      rdata_q <= addr_q;
                        ready_q <= 1'b1;
                        state_q <= ST_DONE;
                     end
                     HIT_CFG, HIT_IO: begin
                        req_q   <= 1'b1;
                        io_q    <= (hit == HIT_IO);
                        we_q    <= h_we;
                        be_q    <= be_now;
                        wdata_q <= h_wdata;
                        state_q <= ST_WAIT;
                     end
                     default: begin
                        if (!h_we) rdata_q <= '0;
                        ready_q <= 1'b1;
                        state_q <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_WAIT: begin
               if (dn_ack) begin
                  req_q   <= 1'b0;
                  if (!we_q) rdata_q <= rd_lanes;
                  ready_q <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            default: begin
               ready_q <= 1'b0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign h_rdata  = rdata_q;
   assign h_ready  = ready_q;
   assign dn_req   = req_q;
   assign dn_io    = io_q;
   assign dn_we    = we_q;
   assign dn_be    = be_q;
   assign dn_wdata = wdata_q;
   assign dn_addr  = io_q ? addr_q : {addr_q[DATA_W-1:2], 2'b00};
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              h_req,
   input logic              h_ready,
   input logic              dn_req,
   input logic              dn_ack,
   input logic              dn_io,
   input logic              dn_we,
   input logic [DATA_W-1:0] dn_addr,
   input logic [LANES-1:0]  dn_be,
   input logic [DATA_W-1:0] dn_wdata
);
   // R6
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |=> !h_ready);

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && !dn_ack |=> dn_req);

   // R6
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && !dn_ack |=> $stable(dn_addr) && $stable(dn_be) && $stable(dn_we)
                            && $stable(dn_io) && $stable(dn_wdata));

   // R6
   ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && dn_ack |=> h_ready && !dn_req);

   // R6
   no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> !h_ready);

   // R5
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> ($countones(dn_be) == 1 || $countones(dn_be) == 2 || $countones(dn_be) == 4));

   // R3
   launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn_req) |-> $past(h_req));
endmodule

bind cfgp_port cfgp_port_chk #(.DATA_W(DATA_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .h_req   (h_req),
   .h_ready (h_ready),
   .dn_req  (dn_req),
   .dn_ack  (dn_ack),
   .dn_io   (dn_io),
   .dn_we   (dn_we),
   .dn_addr (dn_addr),
   .dn_be   (dn_be),
   .dn_wdata(dn_wdata)
);

// File: tb/test_cfgp_port.sv
`timescale 1ns/1ps
module test_cfgp_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0;
   logic        h_we = 1'b0;
   logic [11:0] h_addr = '0;
   logic [1:0]  h_size = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_ready;
   logic        dn_req;
   logic        dn_io;
   logic        dn_we;
   logic [31:0] dn_addr;
   logic [3:0]  dn_be;
   logic [31:0] dn_wdata;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_addr = '0;
   bit          m_pending = 1'b0;
   logic [31:0] m_dn_addr = '0;

   always #5 clk = ~clk;

   cfgp_port i_cfgp_port (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
      .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
      .dn_req(dn_req), .dn_io(dn_io), .dn_we(dn_we), .dn_addr(dn_addr),
      .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison with the model, away from the edge
   always @(posedge clk) begin
      #3;
      if (rst_n && !done) begin
         check("R6 dn_req vs model", 32'(dn_req), 32'(m_pending));
         if (dn_req) check("R4 dn_addr vs model", dn_addr, m_dn_addr);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] ofs);
      case (sz)
         2'd0: return 4'b0001 << ofs;
         2'd1: return ofs[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] lane_mask(logic [3:0] be);
      logic [31:0] m;
      for (int l = 0; l < 4; l++) m[l*8 +: 8] = be[l] ? 8'hFF : 8'h00;
      return m;
   endfunction

   // register access (address register or unmapped)
   task automatic reg_acc(bit we, logic [11:0] a, logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      h_req = 1'b1; h_we = we; h_addr = a; h_size = 2'd2; h_wdata = wd;
      if (we && a[11:2] == 10'h019) m_addr = wd;
      @(negedge clk);
      check("R10/R2 ready after one cycle", 32'(h_ready), 32'd1);
      rd = h_rdata;
      h_req = 1'b0;
   endtask

   // window access with a downstream stall of dly cycles
   task automatic win_acc(bit we, logic [11:0] a, logic [1:0] sz, logic [31:0] wd,
                          int dly, logic [31:0] ack_d);
      logic [3:0]  be;
      bit          io;
      logic [31:0] exp_rd;
      be = exp_be(sz, a[1:0]);
      io = (a[11:2] == 10'h01B);
      @(negedge clk);
      h_req = 1'b1; h_we = we; h_addr = a; h_size = sz; h_wdata = wd;
      m_dn_addr = io ? m_addr : {m_addr[31:2], 2'b00};
      m_pending = 1'b1;
      @(negedge clk);
      check("R6 dn_req one cycle after accept", 32'(dn_req), 32'd1);
      check("R3 dn_io", 32'(dn_io), 32'(io));
      check("R3 dn_we", 32'(dn_we), 32'(we));
      check("R4 dn_addr", dn_addr, m_dn_addr);
      check("R5 dn_be", 32'(dn_be), 32'(be));
      if (we) check("R8 dn_wdata", dn_wdata, wd);
      for (int i = 0; i < dly; i++) begin
         @(negedge clk);
         check("R6 held while stalled", 32'({dn_req, h_ready}), 32'b10);
      end
      dn_ack = 1'b1; dn_rdata = ack_d;
      m_pending = 1'b0;
      @(negedge clk);
      dn_ack = 1'b0; dn_rdata = 32'hDEAD_BEEF;
      check("R6 ready after ack", 32'({h_ready, dn_req}), 32'b10);
      exp_rd = ack_d & lane_mask(be);
      if (!we) check("R7 read lanes", h_rdata, exp_rd);
      h_req = 1'b0;
      @(negedge clk);
      check("R6 ready one cycle only", 32'(h_ready), 32'd0);
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      check("R1 ready low in reset", 32'(h_ready), 32'd0);
      check("R1 dn_req low in reset", 32'(dn_req), 32'd0);
      rst_n = 1'b1;
      reg_acc(1'b0, 12'h064, 32'h0, rd);
      check("R1 address register zero after reset", rd, 32'h0);

      // configuration token: bus 0x12, devfn 0x34, register 0x0B (low bits set)
      reg_acc(1'b1, 12'h064, 32'h0012_340B, rd);
      reg_acc(1'b0, 12'h064, 32'h0, rd);
      check("R2 address register read-back", rd, 32'h0012_340B);

      win_acc(1'b0, 12'h068, 2'd2, 32'h0, 0, 32'hA1B2_C3D4);
      win_acc(1'b0, 12'h068, 2'd0, 32'h0, 1, 32'h1122_3344);
      win_acc(1'b0, 12'h069, 2'd0, 32'h0, 0, 32'h1122_3344);
      win_acc(1'b0, 12'h06A, 2'd0, 32'h0, 3, 32'h1122_3344);
      win_acc(1'b0, 12'h06B, 2'd0, 32'h0, 0, 32'h1122_3344);
      win_acc(1'b1, 12'h068, 2'd1, 32'h0000_5A5A, 2, 32'h0);
      win_acc(1'b1, 12'h06A, 2'd1, 32'h7E7E_0000, 0, 32'h0);
      win_acc(1'b0, 12'h069, 2'd1, 32'h0, 7, 32'hCAFE_F00D);
      win_acc(1'b0, 12'h06B, 2'd1, 32'h0, 4, 32'hCAFE_F00D);
      win_acc(1'b1, 12'h068, 2'd3, 32'h8765_4321, 1, 32'h0);
      reg_acc(1'b0, 12'h064, 32'h0, rd);
      check("R9 address reused unchanged", rd, 32'h0012_340B);

      // I/O port address written unmodified
      reg_acc(1'b1, 12'h064, 32'h0000_BEEF, rd);
      win_acc(1'b0, 12'h06D, 2'd0, 32'h0, 2, 32'h0099_8877);
      win_acc(1'b1, 12'h06C, 2'd2, 32'h0BAD_F00D, 0, 32'h0);
      win_acc(1'b0, 12'h06E, 2'd1, 32'h0, 5, 32'h1357_9BDF);

      // unmapped offsets
      reg_acc(1'b1, 12'h070, 32'hFFFF_FFFF, rd);
      reg_acc(1'b0, 12'h064, 32'h0, rd);
      check("R10 unmapped write leaves address register", rd, 32'h0000_BEEF);
      reg_acc(1'b0, 12'h040, 32'h0, rd);
      check("R10 unmapped read returns zero", rd, 32'h0);
      reg_acc(1'b0, 12'h067, 32'h0, rd);
      check("R2 byte offset within address register", rd, 32'h0000_BEEF);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule